// File: doc/BRIEF.md
# Word/Byte ALU with Status Flags

A purely combinational two-operand arithmetic and logic unit for the execute stage of a 16-bit processor. It takes a source operand, a destination operand, the current carry flag, a width select and a 4-bit operation code. It returns the result, a result write enable, next values for the four status flags, and one update enable per flag. Register access, operand fetch and instruction decode sit around it in the datapath. Decimal arithmetic and shifts are handled by other units.

Ten operations are supported: add, add with carry, subtract, subtract with carry (borrow), compare, AND, bit test, bit clear, bit set and XOR. Subtraction is built as dst + NOT(src) + carry-in, so the carry flag reads as "no borrow". Compare and bit test only produce flags. Bit clear and bit set only produce a result. In byte mode bit 7 is the sign and bit 8 the carry position, and the result is zero-extended.

Top module: `alu_wb_core`

## Requirements
- R1: op 0 (add) returns dst+src and op 1 (add with carry) returns dst+src+carry_i. C is the carry out of the sign bit, V is set when the signed sum is outside the signed range, N is the result sign and Z flags a zero result.
- R2: op 2 (subtract) returns dst+NOT(src)+1 and op 3 (subtract with carry) returns dst+NOT(src)+carry_i. C=1 means no borrow and C=0 means a borrow. V marks signed overflow of the difference.
- R3: op 4 (compare) sets all four flags exactly as subtract does, and res_we_o is 0.
- R4: op 5 (AND) and op 9 (XOR) write the result. N is the result sign, Z flags a zero result and C equals NOT Z. V is 0 for AND. For XOR, V is 1 only when both operands are negative.
- R5: op 6 (bit test) sets the flags exactly as AND does, and res_we_o is 0.
- R6: op 7 (bit clear) writes NOT(src) AND dst and op 8 (bit set) writes src OR dst. Both hold flags_we_o at 0.
- R7: with byte_i=1 only bits 7:0 of the operands take part. Bit 7 is the sign, the carry comes out of bit 7, res_o[15:8] is 0, and Z covers bits 7:0 only.
- R8: flags_o and flags_we_o use bit 0 for C, bit 1 for Z, bit 2 for N and bit 3 for V. Every op except 7 and 8 enables all four flags. Op codes 10 to 15 give res_o=0, res_we_o=0 and flags_we_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| carry_i | input | 1 | Current carry flag |
| byte_i | input | 1 | 1 selects 8-bit operation |
| op_i | input | 4 | Operation code |
| res_o | output | 16 | Result, zero-extended in byte mode |
| res_we_o | output | 1 | Result is to be written back |
| flags_o | output | 4 | Next flag values {V,N,Z,C} |
| flags_we_o | output | 4 | Per-flag update enables {V,N,Z,C} |

## Verification
The hardest cases to reach are in byte mode, where a set upper byte must affect neither the carry nor the sign nor Z. Overflow and borrow must come from bit 7, while the same operands in word mode give different flags. The sweep runs every operation in both widths and with both carry values over a set of operands built around 0x7F, 0x80, 0xFF, 0x7FFF, 0x8000 and 0xFFFF. Several of these operands carry a nonzero upper byte under an 8-bit corner value, so that byte-mode results are compared against a signed-range reference model.

// File: rtl/alu_wb_pkg.sv
package alu_wb_pkg;
  localparam int unsigned OP_W  = 4;
  localparam int unsigned FLG_W = 4;
  localparam int unsigned FLG_C = 0;
  localparam int unsigned FLG_Z = 1;
  localparam int unsigned FLG_N = 2;
  localparam int unsigned FLG_V = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_BIT  = 4'd6,
    OP_BIC  = 4'd7,
    OP_BIS  = 4'd8,
    OP_XOR  = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_BIC = 2'd1,
    LG_BIS = 2'd2,
    LG_XOR = 2'd3
  } logic_fn_e;

  typedef struct packed {
    logic       valid;
    logic       arith;
    logic       inv_src;
    logic       cin_flag;
    logic       cin_const;
    logic_fn_e  lfn;
    logic       res_we;
    logic       flags_we;
  } op_ctl_t;
endpackage

// File: rtl/alu_wb_decode.sv
module alu_wb_decode
  import alu_wb_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output op_ctl_t         ctl_o
);
  always_comb begin
    ctl_o = '{valid: 1'b1, arith: 1'b0, inv_src: 1'b0, cin_flag: 1'b0,
              cin_const: 1'b0, lfn: LG_AND, res_we: 1'b1, flags_we: 1'b1};
    case (op_i)
      OP_ADD:  ctl_o.arith = 1'b1;
      OP_ADDC: begin ctl_o.arith = 1'b1; ctl_o.cin_flag = 1'b1; end
      OP_SUB:  begin ctl_o.arith = 1'b1; ctl_o.inv_src = 1'b1; ctl_o.cin_const = 1'b1; end
      OP_SUBC: begin ctl_o.arith = 1'b1; ctl_o.inv_src = 1'b1; ctl_o.cin_flag = 1'b1; end
      OP_CMP:  begin
        ctl_o.arith = 1'b1; ctl_o.inv_src = 1'b1; ctl_o.cin_const = 1'b1;
        ctl_o.res_we = 1'b0;
      end
      OP_AND:  ctl_o.lfn = LG_AND;
      OP_BIT:  begin ctl_o.lfn = LG_AND; ctl_o.res_we = 1'b0; end
      OP_BIC:  begin ctl_o.lfn = LG_BIC; ctl_o.flags_we = 1'b0; end
      OP_BIS:  begin ctl_o.lfn = LG_BIS; ctl_o.flags_we = 1'b0; end
      OP_XOR:  ctl_o.lfn = LG_XOR;
      default: begin
        ctl_o.valid = 1'b0; ctl_o.res_we = 1'b0; ctl_o.flags_we = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu_wb_adder.sv
module alu_wb_adder #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              ovf_o
);
  localparam int unsigned HI_W = DATA_W - BYTE_W;

  logic [DATA_W:0] wide;
  logic [BYTE_W:0] narrow;
  logic            a_s, b_s, r_s;

  assign wide   = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
  assign narrow = {1'b0, a_i[BYTE_W-1:0]} + {1'b0, b_i[BYTE_W-1:0]}
                + {{BYTE_W{1'b0}}, cin_i};

  always_comb begin
    if (byte_i) begin
      sum_o  = {{HI_W{1'b0}}, narrow[BYTE_W-1:0]};
      cout_o = narrow[BYTE_W];
      a_s    = a_i[BYTE_W-1];
      b_s    = b_i[BYTE_W-1];
      r_s    = narrow[BYTE_W-1];
    end else begin
      sum_o  = wide[DATA_W-1:0];
      cout_o = wide[DATA_W];
      a_s    = a_i[DATA_W-1];
      b_s    = b_i[DATA_W-1];
      r_s    = wide[DATA_W-1];
    end
  end

  // same-sign inputs, different-sign result
  assign ovf_o = (a_s == b_s) && (r_s != a_s);
endmodule

// File: rtl/alu_wb_logic.sv
module alu_wb_logic
  import alu_wb_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic_fn_e         fn_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    case (fn_i)
      LG_AND:  res_o = src_i & dst_i;
      LG_BIC:  res_o = ~src_i & dst_i;
      LG_BIS:  res_o = src_i | dst_i;
      default: res_o = src_i ^ dst_i;
    endcase
  end
endmodule

// File: rtl/alu_wb_flags.sv
module alu_wb_flags
  import alu_wb_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              byte_i,
  input  logic              arith_i,
  input  logic              is_xor_i,
  input  logic              cout_i,
  input  logic              ovf_i,
  input  logic              src_s_i,
  input  logic              dst_s_i,
  output logic [FLG_W-1:0]  flags_o
);
  logic neg, zero;

  assign neg  = byte_i ? res_i[BYTE_W-1] : res_i[DATA_W-1];
  assign zero = byte_i ? (res_i[BYTE_W-1:0] == '0) : (res_i == '0);

  always_comb begin
    flags_o        = '0;
    flags_o[FLG_N] = neg;
    flags_o[FLG_Z] = zero;
    if (arith_i) begin
      flags_o[FLG_C] = cout_i;
      flags_o[FLG_V] = ovf_i;
    end else begin
      flags_o[FLG_C] = ~zero;
      flags_o[FLG_V] = is_xor_i & src_s_i & dst_s_i;
    end
  end
endmodule

// File: rtl/alu_wb_core.sv
module alu_wb_core
  import alu_wb_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic              carry_i,
  input  logic              byte_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_we_o,
  output logic [FLG_W-1:0]  flags_o,
  output logic [FLG_W-1:0]  flags_we_o
);
  localparam int unsigned HI_W = DATA_W - BYTE_W;

  op_ctl_t           ctl;
  logic [DATA_W-1:0] add_b, sum, lg_raw, lg_res, res_sel;
  logic              cin, cout, ovf, src_s, dst_s;

  alu_wb_decode u_dec (.op_i(op_i), .ctl_o(ctl));

  assign add_b = ctl.inv_src ? ~src_i : src_i;
  assign cin   = ctl.cin_flag ? carry_i : ctl.cin_const;

  alu_wb_adder #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_add (
    .a_i(dst_i), .b_i(add_b), .cin_i(cin), .byte_i(byte_i),
    .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
  );

  alu_wb_logic #(.DATA_W(DATA_W)) u_lg (
    .src_i(src_i), .dst_i(dst_i), .fn_i(ctl.lfn), .res_o(lg_raw)
  );

  assign lg_res  = byte_i ? {{HI_W{1'b0}}, lg_raw[BYTE_W-1:0]} : lg_raw;
  assign res_sel = ctl.arith ? sum : lg_res;
  assign src_s   = byte_i ? src_i[BYTE_W-1] : src_i[DATA_W-1];
  assign dst_s   = byte_i ? dst_i[BYTE_W-1] : dst_i[DATA_W-1];

  alu_wb_flags #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_flg (
    .res_i(res_sel), .byte_i(byte_i), .arith_i(ctl.arith),
    .is_xor_i(ctl.lfn == LG_XOR), .cout_i(cout), .ovf_i(ovf),
    .src_s_i(src_s), .dst_s_i(dst_s), .flags_o(flags_o)
  );

  assign res_o      = ctl.valid ? res_sel : '0;
  assign res_we_o   = ctl.res_we;
  assign flags_we_o = {FLG_W{ctl.flags_we}};
endmodule

// File: rtl/alu_wb_checker.sv
module alu_wb_checker
  import alu_wb_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input logic [DATA_W-1:0] src_i,
  input logic [DATA_W-1:0] dst_i,
  input logic              carry_i,
  input logic              byte_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] res_o,
  input logic              res_we_o,
  input logic [FLG_W-1:0]  flags_o,
  input logic [FLG_W-1:0]  flags_we_o
);
  always_comb begin
    if (op_i == OP_ADD && !byte_i && !carry_i) begin
      a_r1_add_ovf: assert (flags_o[FLG_V] ==
        ((src_i[DATA_W-1] == dst_i[DATA_W-1]) && (res_o[DATA_W-1] != src_i[DATA_W-1])))
        else $error("a_r1_add_ovf");
    end
    if (op_i == OP_CMP) begin
      a_r3_cmp_no_write: assert (!res_we_o && flags_we_o == '1)
        else $error("a_r3_cmp_no_write");
    end
    if (op_i == OP_AND || op_i == OP_BIT || op_i == OP_XOR) begin
      a_r4_c_not_z: assert (flags_o[FLG_C] == !flags_o[FLG_Z])
        else $error("a_r4_c_not_z");
    end
    if (op_i == OP_BIT) begin
      a_r5_bit_no_write: assert (!res_we_o) else $error("a_r5_bit_no_write");
    end
    if (op_i == OP_BIC || op_i == OP_BIS) begin
      a_r6_keep_flags: assert (res_we_o && flags_we_o == '0)
        else $error("a_r6_keep_flags");
    end
    if (byte_i) begin
      a_r7_byte_zext: assert (res_o[DATA_W-1:BYTE_W] == '0)
        else $error("a_r7_byte_zext");
    end
    if (op_i > OP_XOR) begin
      a_r8_undef_quiet: assert (!res_we_o && flags_we_o == '0 && res_o == '0)
        else $error("a_r8_undef_quiet");
    end
  end
endmodule

bind alu_wb_core alu_wb_checker #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .src_i(src_i), .dst_i(dst_i), .carry_i(carry_i), .byte_i(byte_i), .op_i(op_i),
  .res_o(res_o), .res_we_o(res_we_o), .flags_o(flags_o), .flags_we_o(flags_we_o)
);

// File: tb/alu_wb_core_tb.sv
module alu_wb_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVAL = 12;

  logic        clk = 1'b0;
  logic [15:0] src, dst, res;
  logic        carry, byt, res_we;
  logic [3:0]  op, flags, flags_we;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_wb_core dut_i (
    .src_i(src), .dst_i(dst), .carry_i(carry), .byte_i(byt), .op_i(op),
    .res_o(res), .res_we_o(res_we), .flags_o(flags), .flags_we_o(flags_we)
  );

  function automatic logic [15:0] pick(input int k);
    case (k)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h007F;
      3: return 16'h0080;  4: return 16'h00FF;  5: return 16'h7FFF;
      6: return 16'h8000;  7: return 16'hFFFF;  8: return 16'hFFFE;
      9: return 16'h5555; 10: return 16'hAA80; default: return 16'h127F;
    endcase
  endfunction

  function automatic string tag_of(input int o, input bit b);
    if (b) return "R7";
    case (o)
      0, 1: return "R1";
      2, 3: return "R2";
      4: return "R3";
      5, 9: return "R4";
      6: return "R5";
      7, 8: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic run_one(input int o, input bit b, input bit ci,
                         input logic [15:0] s_in, input logic [15:0] d_in);
    int w, mask, half, d, s, bb, cin, r, sd, sb, ssum;
    logic [15:0] e_res;
    logic [3:0]  e_flg, e_we;
    logic        e_rwe, c, v, n, z;
    string       tag;
    w = b ? 8 : 16; mask = (1 << w) - 1; half = 1 << (w - 1);
    d = int'(d_in) & mask; s = int'(s_in) & mask;
    c = 0; v = 0; r = 0; e_rwe = 0; e_we = 4'h0;
    if (o <= 4) begin
      bb  = (o >= 2) ? (~s & mask) : s;
      cin = (o == 0) ? 0 : ((o == 2 || o == 4) ? 1 : int'(ci));
      r   = d + bb + cin;
      c   = ((r >> w) & 1) != 0;
      r   = r & mask;
      sd  = (d >= half) ? d - (1 << w) : d;
      sb  = (bb >= half) ? bb - (1 << w) : bb;
      ssum = sd + sb + cin;
      v   = (ssum < -half) || (ssum > half - 1);
      e_rwe = (o != 4); e_we = 4'hF;
    end else if (o <= 9) begin
      case (o)
        5, 6: r = s & d;
        7:    r = ~s & d & mask;
        8:    r = s | d;
        default: r = s ^ d;
      endcase
      c = (r != 0);
      v = (o == 9) && (s >= half) && (d >= half);
      e_rwe = (o != 6);
      e_we  = (o == 7 || o == 8) ? 4'h0 : 4'hF;
    end
    n = ((r >> (w - 1)) & 1) != 0;
    z = (r == 0);
    e_res = (o <= 9) ? r[15:0] : 16'h0000;
    e_flg = {v, n, z, c};
    tag = tag_of(o, b);
    @(negedge clk);
    op = o[3:0]; byt = b; carry = ci; src = s_in; dst = d_in;
    #(CLK_PERIOD/4);
    n_chk++;
    if (res !== e_res || res_we !== e_rwe || flags_we !== e_we ||
        (flags & e_we) !== (e_flg & e_we)) begin
      n_fail++;
      $display("FAIL %s op=%0d byte=%0b c=%0b src=%h dst=%h: res=%h we=%b flg=%b fwe=%b exp res=%h we=%b flg=%b fwe=%b",
               tag, o, b, ci, s_in, d_in, res, res_we, flags, flags_we,
               e_res, e_rwe, e_flg, e_we);
    end
  endtask

  initial begin
    op = 4'd0; byt = 1'b0; carry = 1'b0; src = '0; dst = '0;
    // R1 idle check: zero operands add gives zero with Z set
    run_one(0, 1'b0, 1'b0, 16'h0000, 16'h0000);
    // R1 R2 R3 R4 R5 R6 R7 R8: full sweep
    for (int o = 0; o < 16; o++)
      for (int b = 0; b < 2; b++)
        for (int ci = 0; ci < 2; ci++)
          for (int i = 0; i < NVAL; i++)
            for (int j = 0; j < NVAL; j++)
              run_one(o, b[0], ci[0], pick(i), pick(j));
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule